// File: doc/BRIEF.md
# Write-Back Data Cache with Run-Time Write-Miss Policy

This block is a small fully associative data cache that sits between a processor-side request port and a word-wide backing memory. Each entry holds one word, so a block and a word are the same thing. The processor presents an address, a read/write flag and write data. It waits on a ready signal while the cache looks up the address and, on a miss, talks to memory over a request/acknowledge handshake. Modified words stay in the cache until their entry is reclaimed, and are written back to memory at that point.

A static configuration input chooses what happens on a write miss. In allocate mode, the word is fetched, installed and then overwritten in the cache. In write-around mode, the word goes straight to memory and no entry is created. Read misses always install the fetched word. Victims are reclaimed in round-robin order of allocation. Two saturating counters record how many completed requests hit and how many missed, so a user can compare the two policies on the same access stream.

Top module: `wb_cache_top`

## Requirements
- R1: Any address can occupy any of the ENTRIES slots. After ENTRIES distinct addresses have been read, a repeat access to each of them is a hit.
- R2: A read hit returns the stored word on cpu_rdata and issues no memory request.
- R3: A write hit updates the cached word and marks it modified, with no memory request. The new value is returned by a later read hit.
- R4: A read miss issues one memory read (mem_we=0) at the requested address. It installs the word as unmodified and returns it on cpu_rdata.
- R5: With cfg_wr_alloc=1, a write miss issues one memory read at the address. The write data is then placed in the new entry, which is marked modified, and memory is not written.
- R6: With cfg_wr_alloc=0, a write miss issues one memory write (mem_we=1) of the data at the address and creates no entry, so a following access to that address misses again.
- R7: Allocation reuses slots in round-robin order starting at slot 0 after reset. A modified victim is written to memory at its own address before the fill read, and an unmodified victim causes no memory write.
- R8: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata hold steady until the cycle in which mem_ack is seen high.
- R9: cpu_req is taken only while cpu_ready is high. cpu_ready is low in the cycle after acceptance and returns high when the request completes.
- R10: Each completed request adds exactly one to hit_count (hit) or to miss_count (miss), in the cycle cpu_ready returns high. Each counter stops at its all-ones value.
- R11: From an empty cache, the sequence write A, write A, read B, write B, write A gives 1 hit and 4 misses with cfg_wr_alloc=0, and 3 hits and 2 misses with cfg_wr_alloc=1.
- R12: After reset, cpu_ready is 1, mem_req is 0, both counters are 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_alloc | input | 1 | 1: allocate on write miss; 0: write around |
| cpu_req | input | 1 | Request valid, taken while cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when a read completes |
| cpu_ready | output | 1 | Idle and able to take a request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The embedded properties watch, on every cycle, that at most one slot matches a lookup and that no slot is modified without being valid. They also check that a pending memory request keeps its fields steady, that a hit never leads to memory traffic, that ready drops after acceptance, and that each counter moves by at most one per cycle. Which operation hits depends on the policy and on the round-robin victim choice, so only the bench scenarios can show it. The same holds for write-back of a modified victim carrying the right data, for the absence of an entry after a write-around, and for counter saturation. The bench observes these through returned data, counters and a modelled memory.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_ISSUE,
    ST_FILL,
    ST_AROUND
  } cache_state_e;
endpackage

// File: rtl/wb_cache_tags.sv
module wb_cache_tags #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [IDX_W-1:0]  vic_idx,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [ADDR_W-1:0] vic_tag,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_tag,
  input  logic              alloc_dirty
);
  logic [ENTRIES-1:0] valid_q, dirty_q, match_vec;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == look_addr);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end

  assign vic_idx   = ptr_q;
  assign vic_valid = valid_q[ptr_q];
  assign vic_dirty = dirty_q[ptr_q];
  assign vic_tag   = tag_q[ptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (upd_en) dirty_q[upd_idx] <= 1'b1;
      if (alloc_en) begin
        valid_q[ptr_q] <= 1'b1;
        dirty_q[ptr_q] <= alloc_dirty;
        ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[ptr_q] <= alloc_tag;
  end

  // R1: an address lives in at most one slot
  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R7: a modified slot is always a valid slot
  a_r7_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/wb_cache_data.sv
module wb_cache_data #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/wb_cache_counter.sv
module wb_cache_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end

  // R10: one step per cycle at most, never backwards
  a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/wb_cache_top.sv
module wb_cache_top
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_alloc,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  cache_state_e state_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic              tag_hit, vic_valid, vic_dirty;
  logic [IDX_W-1:0]  hit_idx, vic_idx, rd_idx;
  logic [ADDR_W-1:0] vic_tag;
  logic [DATA_W-1:0] slot_rdata;

  logic              upd_en, alloc_en, alloc_dirty, dat_we;
  logic [IDX_W-1:0]  dat_widx;
  logic [DATA_W-1:0] dat_wdata;
  logic              cnt_hit, cnt_miss;

  assign rd_idx = tag_hit ? hit_idx : vic_idx;

  wb_cache_tags #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_tags (
    .clk(clk), .rst(rst), .look_addr(req_addr_q),
    .hit(tag_hit), .hit_idx(hit_idx),
    .vic_idx(vic_idx), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .upd_en(upd_en), .upd_idx(hit_idx),
    .alloc_en(alloc_en), .alloc_tag(req_addr_q), .alloc_dirty(alloc_dirty)
  );

  wb_cache_data #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_data (
    .clk(clk), .we(dat_we), .widx(dat_widx), .wdata(dat_wdata),
    .ridx(rd_idx), .rdata(slot_rdata)
  );

  wb_cache_counter #(.CNT_W(CNT_W)) u_hits (
    .clk(clk), .rst(rst), .inc(cnt_hit), .count(hit_count)
  );

  wb_cache_counter #(.CNT_W(CNT_W)) u_misses (
    .clk(clk), .rst(rst), .inc(cnt_miss), .count(miss_count)
  );

  // Array updates and accounting for the current state
  always_comb begin
    upd_en      = 1'b0;
    alloc_en    = 1'b0;
    alloc_dirty = 1'b0;
    dat_we      = 1'b0;
    dat_widx    = hit_idx;
    dat_wdata   = req_wdata_q;
    cnt_hit     = 1'b0;
    cnt_miss    = 1'b0;
    unique case (state_q)
      ST_LOOK: if (tag_hit) begin
        cnt_hit = 1'b1;
        if (req_we_q) begin
          upd_en = 1'b1;
          dat_we = 1'b1;
        end
      end
      ST_FILL: if (mem_ack) begin
        alloc_en    = 1'b1;
        alloc_dirty = req_we_q;
        dat_we      = 1'b1;
        dat_widx    = vic_idx;
        dat_wdata   = req_we_q ? req_wdata_q : mem_rdata;
        cnt_miss    = 1'b1;
      end
      ST_AROUND: if (mem_ack) cnt_miss = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cpu_ready   <= 1'b1;
      cpu_rdata   <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req) begin
          req_we_q    <= cpu_we;
          req_addr_q  <= cpu_addr;
          req_wdata_q <= cpu_wdata;
          cpu_ready   <= 1'b0;
          state_q     <= ST_LOOK;
        end
        ST_LOOK: begin
          if (tag_hit) begin
            if (!req_we_q) cpu_rdata <= slot_rdata;
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (req_we_q && !cfg_wr_alloc) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= req_addr_q;
            mem_wdata <= req_wdata_q;
            state_q   <= ST_AROUND;
          end else if (vic_valid && vic_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= vic_tag;
            mem_wdata <= slot_rdata;
            state_q   <= ST_EVICT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= req_addr_q;
            state_q  <= ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) begin
          mem_req <= 1'b0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= req_addr_q;
          state_q  <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          mem_req <= 1'b0;
          if (!req_we_q) cpu_rdata <= mem_rdata;
          cpu_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_AROUND: if (mem_ack) begin
          mem_req   <= 1'b0;
          cpu_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: pending memory request keeps its fields until acknowledged
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  // R2: a lookup that hits does not start memory traffic
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && tag_hit) |=> !mem_req);

  // R9: acceptance drops ready on the next cycle
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  // R10: counters never both advance for one request
  a_r10_one_count: assert property (@(posedge clk) disable iff (rst)
    !(cnt_hit && cnt_miss));
endmodule

// File: tb/wb_cache_top_bench.sv
module wb_cache_top_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_alloc = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic [CW-1:0] hit_count, miss_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wb_cache_top #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(4), .CNT_W(CW)) u_wb_cache_top (
    .clk(clk), .rst(rst), .cfg_wr_alloc(cfg_wr_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // Backing memory model: acknowledges after a short wait
  logic [DW-1:0] mem_arr [256];
  bit            mem_init = 1'b0;
  int            wait_n = 0;
  int            mem_rd_n = 0, mem_wr_n = 0, hold_err = 0;
  logic [AW-1:0] last_wr_addr, held_addr;
  logic [DW-1:0] last_wr_data;

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= 32'hA000_0000 + i;
    end
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wait_n  <= 0;
    end else if (mem_req) begin
      if (wait_n == 0) held_addr <= mem_addr;
      else if (held_addr != mem_addr) hold_err <= hold_err + 1;
      if (wait_n == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_arr[mem_addr] <= mem_wdata;
          mem_wr_n     <= mem_wr_n + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata <= mem_arr[mem_addr];
          mem_rd_n  <= mem_rd_n + 1;
        end
      end
      wait_n <= wait_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit alloc);
    @(negedge clk);
    rst = 1'b1;
    cfg_wr_alloc = alloc;
    mem_init = 1'b1;
    @(negedge clk);
    mem_init = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready) @(negedge clk);
    rd = cpu_rdata;
  endtask

  // Runs one op and checks hit/miss outcome from the counters
  task automatic op_expect(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit exp_hit, input string req, output logic [DW-1:0] rd);
    logic [CW-1:0] h0;
    h0 = hit_count;
    do_op(we, a, d, rd);
    chk((hit_count != h0) == exp_hit, req, 32'(hit_count != h0), 32'(exp_hit));
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk(cpu_ready == 1'b1, "R12 ready", 32'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 0);
    chk(hit_count == 0 && miss_count == 0, "R12 counters",
        {hit_count, miss_count}, 0);
  endtask

  task automatic t_ref_around;
    logic [DW-1:0] rd;
    int w0;
    do_reset(1'b0);
    w0 = mem_wr_n;
    op_expect(1'b1, 8'h64, 32'h1111, 1'b0, "R11 around op1", rd);
    chk(mem_wr_n == w0 + 1 && last_wr_addr == 8'h64 && last_wr_data == 32'h1111,
        "R6 write-around to memory", last_wr_data, 32'h1111);
    op_expect(1'b1, 8'h64, 32'h2222, 1'b0, "R6 no entry after around (op2)", rd);
    op_expect(1'b0, 8'hC8, 0, 1'b0, "R11 around op3", rd);
    op_expect(1'b1, 8'hC8, 32'h3333, 1'b1, "R11 around op4", rd);
    op_expect(1'b1, 8'h64, 32'h4444, 1'b0, "R11 around op5", rd);
    chk(hit_count == 1 && miss_count == 4, "R11 around totals",
        {hit_count, miss_count}, {4'd1, 4'd4});
    chk(mem_arr[8'h64] == 32'h4444, "R6 memory holds last around write",
        mem_arr[8'h64], 32'h4444);
  endtask

  task automatic t_ref_alloc;
    logic [DW-1:0] rd;
    int r0, w0;
    do_reset(1'b1);
    r0 = mem_rd_n; w0 = mem_wr_n;
    op_expect(1'b1, 8'h64, 32'h5555, 1'b0, "R11 alloc op1", rd);
    chk(mem_rd_n == r0 + 1 && mem_wr_n == w0, "R5 fill read, no memory write",
        mem_wr_n - w0, 0);
    op_expect(1'b1, 8'h64, 32'h6666, 1'b1, "R11 alloc op2", rd);
    op_expect(1'b0, 8'hC8, 0, 1'b0, "R11 alloc op3", rd);
    chk(rd == 32'hA000_00C8, "R4 read miss data", rd, 32'hA000_00C8);
    op_expect(1'b1, 8'hC8, 32'h7777, 1'b1, "R11 alloc op4", rd);
    op_expect(1'b1, 8'h64, 32'h8888, 1'b1, "R11 alloc op5", rd);
    chk(hit_count == 3 && miss_count == 2, "R11 alloc totals",
        {hit_count, miss_count}, {4'd3, 4'd2});
    op_expect(1'b0, 8'h64, 0, 1'b1, "R3 read back after write hit", rd);
    chk(rd == 32'h8888, "R3 written value", rd, 32'h8888);
    chk(mem_wr_n == w0, "R3 write hits stay out of memory", mem_wr_n - w0, 0);
  endtask

  task automatic t_assoc_fifo;
    logic [DW-1:0] rd;
    logic [AW-1:0] addrs [4];
    int r0, w0;
    addrs[0] = 8'h11; addrs[1] = 8'h82; addrs[2] = 8'hF3; addrs[3] = 8'h04;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) begin
      op_expect(1'b0, addrs[i], 0, 1'b0, "R4 cold read miss", rd);
      chk(rd == 32'hA000_0000 + addrs[i], "R4 fill data", rd, 32'hA000_0000 + addrs[i]);
    end
    r0 = mem_rd_n; w0 = mem_wr_n;
    for (int i = 0; i < 4; i++) begin
      op_expect(1'b0, addrs[i], 0, 1'b1, "R1 any slot hits", rd);
      chk(rd == 32'hA000_0000 + addrs[i], "R2 hit data", rd, 32'hA000_0000 + addrs[i]);
    end
    chk(mem_rd_n == r0 && mem_wr_n == w0, "R2 hits cause no memory access",
        mem_rd_n - r0, 0);
    op_expect(1'b1, addrs[1], 32'hBEEF, 1'b1, "R3 write hit", rd);
    chk(mem_wr_n == w0, "R3 no memory write on hit", mem_wr_n - w0, 0);
    // slot 0 (clean) is the first victim
    op_expect(1'b0, 8'h55, 0, 1'b0, "R7 miss evicting clean slot", rd);
    chk(mem_wr_n == w0, "R7 clean victim not written", mem_wr_n - w0, 0);
    op_expect(1'b0, addrs[0], 0, 1'b0, "R7 oldest entry was evicted", rd);
    // that miss reclaimed slot 1, which held the modified word
    chk(mem_wr_n == w0 + 1 && last_wr_addr == addrs[1], "R7 dirty victim address",
        32'(last_wr_addr), 32'(addrs[1]));
    chk(last_wr_data == 32'hBEEF, "R7 dirty victim data", last_wr_data, 32'hBEEF);
    op_expect(1'b0, addrs[1], 0, 1'b0, "R7 written-back word misses", rd);
    chk(rd == 32'hBEEF, "R7 memory kept write-back", rd, 32'hBEEF);
    op_expect(1'b0, addrs[3], 0, 1'b1, "R7 newest entry survives", rd);
  endtask

  task automatic t_saturate;
    logic [DW-1:0] rd;
    do_reset(1'b1);
    for (int i = 0; i < 17; i++) do_op(1'b0, 8'h07, 0, rd);
    chk(hit_count == 4'hF, "R10 hit counter saturates", hit_count, 4'hF);
    chk(miss_count == 4'd1, "R10 one miss counted", miss_count, 1);
    do_reset(1'b1);
    chk(hit_count == 0, "R10 counters clear on reset", hit_count, 0);
  endtask

  task automatic t_ready;
    logic [DW-1:0] rd;
    logic [CW-1:0] m0;
    do_reset(1'b0);
    m0 = miss_count;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h30;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R9 ready low after accept", 32'(cpu_ready), 0);
    // a request presented while busy must be ignored
    cpu_addr = 8'h31;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready) @(negedge clk);
    chk(cpu_rdata == 32'hA000_0030, "R9 busy request ignored", cpu_rdata, 32'hA000_0030);
    repeat (3) @(negedge clk);
    chk(miss_count == m0 + 1, "R10 single count per request", miss_count, m0 + 1);
    chk(hold_err == 0, "R8 memory fields held", hold_err, 0);
    do_op(1'b0, 8'h30, 0, rd);
  endtask

  initial begin
    t_reset_state();
    t_ref_around();
    t_ref_alloc();
    t_assoc_fifo();
    t_saturate();
    t_ready();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule